// File: doc/BRIEF.md
# Clocked Serial Byte Transmitter

This block sends one byte at a time over a clocked serial link. The host loads a byte through a single-cycle write strobe. If the block is idle it takes the byte, puts bit 0 on the data line at once and shifts the rest out least significant bit first. Each bit is held for two serial-clock half-periods: the active edge samples the bit, and the data line changes only on the inactive edge that follows.

The serial clock has two roles, chosen by a configuration bit. In drive mode the block produces the clock on `sclk_out` and enables the pad through `sclk_oe`. Each pulse of an external `tick_en` strobe advances the clock by one half-period. In follow mode the pad is an input. An external master supplies the clock on `sclk_in`, which passes through a two-flop synchronizer and an edge detector before it moves the shifter. A second configuration bit selects whether the rising or the falling edge is the active one.

After the sixteenth half-period the transfer ends. `busy` drops, the sticky `done` flag sets, and `irq` pulses for one cycle. The host clears `done` by pulsing `clr_done`, or by loading the next byte.

Top module: `sync_serial_tx`

## Requirements
- R1: After reset `txd` is 1, `busy`, `done` and `irq` are 0, and `sclk_out` equals `cfg_fall_edge`.
- R2: A write (`wr_en`=1) while idle makes `busy` 1 from the next cycle, and `txd` shows bit 0 of `wr_data` in that same cycle.
- R3: Bits leave least significant first. Bit k is on `txd` during half-periods 2k and 2k+1 of the transfer. `txd` is 1 whenever the block is idle.
- R4: In drive mode (`cfg_ext_clk`=0), `sclk_oe` is 1. While busy, `sclk_out` toggles in the cycle after each cycle with `tick_en`=1 and holds otherwise, giving 16 toggles per byte. In follow mode `sclk_oe` is 0 and `sclk_out` holds its idle level.
- R5: The clock idles at `cfg_fall_edge`. With 0 the active edge is rising, with 1 it is falling. The first toggle of a transfer is always the active edge, and `txd` changes only at inactive edges.
- R6: In follow mode a write only arms the shifter. If `sclk_in` takes a new level at clock edge e, the block reacts to it at edge e+2. Half-periods advance only on the expected edge kind: first an active edge, then an inactive edge, alternating.
- R7: On the step that ends the 16th half-period, `busy` falls, `done` sets and `irq` is 1 for exactly one cycle, all at the same edge.
- R8: `done` holds until `clr_done`=1 or an accepted write. If completion and clear fall in the same cycle, completion wins.
- R9: A write while `busy`=1 is ignored, and the byte in flight continues unchanged.
- R10: While idle, `tick_en` pulses and `sclk_in` edges change no output.

Top module ports in order:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe for the transmit buffer |
| wr_data | input | DATA_W | Byte to send |
| clr_done | input | 1 | Write-one-to-clear for the completion flag |
| cfg_ext_clk | input | 1 | 0: block drives the serial clock, 1: follows `sclk_in` |
| cfg_fall_edge | input | 1 | 0: rising active edge, 1: falling active edge |
| tick_en | input | 1 | Half-period strobe used in drive mode |
| sclk_in | input | 1 | External serial clock (asynchronous) |
| sclk_out | output | 1 | Generated serial clock |
| sclk_oe | output | 1 | Serial clock pad output enable |
| txd | output | 1 | Serial data output |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Sticky transmit-complete flag |
| irq | output | 1 | One-cycle completion interrupt request |

## Verification
The assertions assume that `cfg_ext_clk` and `cfg_fall_edge` change only while `busy` is 0. They also assume that each level of `sclk_in` lasts at least two system clocks, so the synchronizer never misses an edge. The stimulus respects both: it changes configuration only between transfers and holds every external clock level for four cycles. Writes while busy, clears held through completion, and ticks and pin edges while idle are all applied deliberately. They are compared against a behavioural model that is checked on every clock.

// File: rtl/siotx_pkg.sv
package siotx_pkg;

    localparam int DEF_DATA_W = 8;

    typedef enum logic {
        SCLK_DRIVE  = 1'b0,
        SCLK_FOLLOW = 1'b1
    } clk_role_e;

    typedef struct packed {
        logic act;
        logic inact;
    } edge_ev_t;

    // level the serial clock rests at between transfers
    function automatic logic idle_level(input logic fall_active);
        return fall_active;
    endfunction

endpackage

// File: rtl/siotx_insync.sv
module siotx_insync
    import siotx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     pin,
    input  logic     fall_active,
    output edge_ev_t ev
);
    logic s1, s2, s3;
    logic rise, fall;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= 1'b0;
            s2 <= 1'b0;
            s3 <= 1'b0;
        end else begin
            s1 <= pin;
            s2 <= s1;
            s3 <= s2;
        end
    end

    assign rise     = s2 & ~s3;
    assign fall     = ~s2 & s3;
    assign ev.act   = fall_active ? fall : rise;
    assign ev.inact = fall_active ? rise : fall;

    // R6: a detected rising edge reflects a high pin two samples back
    a_r6_rise_from_pin: assert property (@(posedge clk) disable iff (rst)
        rise |-> $past(pin, 2));
    a_r6_fall_from_pin: assert property (@(posedge clk) disable iff (rst)
        fall |-> !$past(pin, 2));

endmodule

// File: rtl/siotx_sclkgen.sv
module siotx_sclkgen
    import siotx_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic step,
    input  logic fall_active,
    output logic sclk
);
    always_ff @(posedge clk) begin
        if (rst) begin
            sclk <= idle_level(fall_active);
        end else if (!run) begin
            sclk <= idle_level(fall_active);
        end else if (step) begin
            sclk <= ~sclk;
        end
    end

    // R4: clock only moves on a step while running
    a_r4_sclk_hold: assert property (@(posedge clk) disable iff (rst)
        (run && !step) |=> $stable(sclk));
    // R5: idle level follows edge select
    a_r5_idle_level: assert property (@(posedge clk) disable iff (rst)
        !run |=> (sclk == $past(fall_active)));

endmodule

// File: rtl/siotx_shifter.sv
module siotx_shifter #(
    parameter int DATA_W = siotx_pkg::DEF_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              step,
    output logic              busy,
    output logic              want_act,
    output logic              txd,
    output logic              finish
);
    localparam int HALVES = 2 * DATA_W;
    localparam int HALF_W = $clog2(HALVES);
    localparam logic [HALF_W-1:0] LAST = HALF_W'(HALVES - 1);

    logic [DATA_W-1:0] sh;
    logic [HALF_W-1:0] half;

    assign finish   = busy & step & (half == LAST);
    assign want_act = ~half[0];
    assign txd      = busy ? sh[0] : 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            half <= '0;
            sh   <= '0;
        end else if (!busy) begin
            if (load) begin
                busy <= 1'b1;
                half <= '0;
                sh   <= load_data;
            end
        end else if (step) begin
            half <= half + 1'b1;
            if (half[0]) begin
                sh <= sh >> 1;
            end
            if (half == LAST) begin
                busy <= 1'b0;
            end
        end
    end

    // R9: a load during a transfer leaves the byte and progress alone
    a_r9_write_ignored: assert property (@(posedge clk) disable iff (rst)
        (busy && load && !step) |=> (busy && $stable(sh) && $stable(half)));
    // R5: data never moves on an active edge
    a_r5_hold_on_active: assert property (@(posedge clk) disable iff (rst)
        (busy && step && want_act) |=> $stable(sh));

endmodule

// File: rtl/sync_serial_tx.sv
module sync_serial_tx
    import siotx_pkg::*;
#(
    parameter int DATA_W = DEF_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              clr_done,
    input  logic              cfg_ext_clk,
    input  logic              cfg_fall_edge,
    input  logic              tick_en,
    input  logic              sclk_in,
    output logic              sclk_out,
    output logic              sclk_oe,
    output logic              txd,
    output logic              busy,
    output logic              done,
    output logic              irq
);
    clk_role_e role;
    edge_ev_t  ev;
    logic      want_act;
    logic      step;
    logic      finish;
    logic      accept;

    assign role    = clk_role_e'(cfg_ext_clk);
    assign sclk_oe = (role == SCLK_DRIVE);
    assign step    = (role == SCLK_FOLLOW) ? (want_act ? ev.act : ev.inact) : tick_en;
    assign accept  = wr_en & ~busy;

    siotx_insync u_sync (
        .clk         (clk),
        .rst         (rst),
        .pin         (sclk_in),
        .fall_active (cfg_fall_edge),
        .ev          (ev)
    );

    siotx_sclkgen u_clkgen (
        .clk         (clk),
        .rst         (rst),
        .run         (busy),
        .step        (step & (role == SCLK_DRIVE)),
        .fall_active (cfg_fall_edge),
        .sclk        (sclk_out)
    );

    siotx_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .load      (wr_en),
        .load_data (wr_data),
        .step      (step),
        .busy      (busy),
        .want_act  (want_act),
        .txd       (txd),
        .finish    (finish)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            done <= 1'b0;
            irq  <= 1'b0;
        end else begin
            irq <= finish;
            if (finish) begin
                done <= 1'b1;
            end else if (accept || clr_done) begin
                done <= 1'b0;
            end
        end
    end

    // R7: completion signals line up
    a_r7_irq_with_done: assert property (@(posedge clk) disable iff (rst)
        irq |-> done);
    a_r7_irq_single: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);
    a_r7_busy_fall_irq: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> irq);
    // R8: flag is sticky
    a_r8_done_hold: assert property (@(posedge clk) disable iff (rst)
        (done && !clr_done && !accept) |=> done);

endmodule

// File: tb/test_sync_serial_tx.sv
module test_sync_serial_tx;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       clr_done = 1'b0;
    logic       cfg_ext_clk = 1'b0;
    logic       cfg_fall_edge = 1'b0;
    logic       tick_en = 1'b0;
    logic       sclk_in = 1'b0;
    logic       sclk_out, sclk_oe, txd, busy, done, irq;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int irq_seen = 0;
    int cap_n = 0;
    logic [7:0] cap = 8'h00;
    logic prev_sclk = 1'b0;

    // behavioural reference state
    int m_busy, m_half, m_data, m_sclk, m_done, m_irq;
    int h1, h2, h3;

    always #(CLK_PERIOD/2) clk = ~clk;

    sync_serial_tx i_sync_serial_tx (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .clr_done(clr_done), .cfg_ext_clk(cfg_ext_clk),
        .cfg_fall_edge(cfg_fall_edge), .tick_en(tick_en), .sclk_in(sclk_in),
        .sclk_out(sclk_out), .sclk_oe(sclk_oe), .txd(txd), .busy(busy),
        .done(done), .irq(irq)
    );

    always @(posedge clk) begin
        int e_rise, e_fall, e_act, e_inact, e_step, e_fin, e_acc;
        if (rst) begin
            m_busy = 0; m_half = 0; m_data = 0; m_done = 0; m_irq = 0;
            m_sclk = int'(cfg_fall_edge);
            h1 = 0; h2 = 0; h3 = 0;
        end else begin
            e_rise  = (h2 == 1 && h3 == 0) ? 1 : 0;
            e_fall  = (h2 == 0 && h3 == 1) ? 1 : 0;
            e_act   = cfg_fall_edge ? e_fall : e_rise;
            e_inact = cfg_fall_edge ? e_rise : e_fall;
            e_step  = cfg_ext_clk ? ((m_half % 2 == 0) ? e_act : e_inact) : int'(tick_en);
            e_fin   = (m_busy == 1 && e_step == 1 && m_half == 15) ? 1 : 0;
            e_acc   = (m_busy == 0 && wr_en) ? 1 : 0;
            if (m_busy == 0) m_sclk = int'(cfg_fall_edge);
            else if (e_step == 1 && !cfg_ext_clk) m_sclk = 1 - m_sclk;
            if (e_acc == 1) begin
                m_busy = 1; m_half = 0; m_data = int'(wr_data);
            end else if (m_busy == 1 && e_step == 1) begin
                if (e_fin == 1) m_busy = 0;
                m_half = (m_half + 1) % 16;
            end
            if (e_fin == 1) m_done = 1;
            else if (e_acc == 1 || clr_done) m_done = 0;
            m_irq = e_fin;
            h3 = h2; h2 = h1; h1 = int'(sclk_in);
        end
    end

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d t=%0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic cycle();
        @(negedge clk);
        chk("R3", "txd", int'(txd), (m_busy == 1) ? ((m_data >> (m_half / 2)) & 1) : 1);
        chk("R4", "sclk_out", int'(sclk_out), m_sclk);
        chk("R4", "sclk_oe", int'(sclk_oe), cfg_ext_clk ? 0 : 1);
        chk("R9", "busy", int'(busy), m_busy);
        chk("R8", "done", int'(done), m_done);
        chk("R7", "irq", int'(irq), m_irq);
        if (irq) irq_seen++;
        if (sclk_out != prev_sclk && sclk_out != cfg_fall_edge && busy) begin
            cap = {txd, cap[7:1]};
            cap_n++;
        end
        prev_sclk = sclk_out;
    endtask

    task automatic run_out(input logic [7:0] d, input int div, input bit extra_wr, input bit hold_clr);
        cfg_ext_clk = 1'b0;
        wr_en = 1'b1; wr_data = d;
        cycle();
        chk("R2", "busy after write", int'(busy), 1);
        chk("R2", "bit0 on txd", int'(txd), int'(d[0]));
        chk("R8", "write clears done", int'(done), 0);
        wr_en = 1'b0;
        irq_seen = 0; cap_n = 0;
        for (int i = 0; i < 16 * div + 6; i++) begin
            tick_en = ((i % div) == div - 1);
            wr_en = (extra_wr && i == 7);
            wr_data = ~d;
            clr_done = hold_clr;
            cycle();
        end
        tick_en = 1'b0; wr_en = 1'b0; clr_done = 1'b0;
        cycle();
        chk("R7", "irq pulses per byte", irq_seen, 1);
        chk("R3", "byte seen at active edges", int'(cap), int'(d));
        chk("R4", "active edges per byte", cap_n, 8);
        chk("R8", "done after byte", int'(done), hold_clr ? 0 : 1);
    endtask

    task automatic run_in(input logic [7:0] d, input logic fe);
        cfg_ext_clk = 1'b1; cfg_fall_edge = fe; sclk_in = fe;
        repeat (4) cycle();
        // R10: pin activity while idle
        sclk_in = ~sclk_in; repeat (4) cycle();
        sclk_in = ~sclk_in; repeat (4) cycle();
        chk("R10", "idle after pin edges", int'(busy), 0);
        chk("R10", "txd idle after pin edges", int'(txd), 1);
        wr_en = 1'b1; wr_data = d;
        cycle();
        wr_en = 1'b0;
        repeat (6) cycle();
        chk("R6", "armed holds bit0", int'(txd), int'(d[0]));
        chk("R6", "armed busy", int'(busy), 1);
        irq_seen = 0;
        for (int k = 0; k < 16; k++) begin
            sclk_in = ~sclk_in;
            repeat (4) cycle();
        end
        repeat (4) cycle();
        chk("R6", "follow mode completes", int'(busy), 0);
        chk("R7", "irq in follow mode", irq_seen, 1);
        chk("R4", "sclk_out idle in follow mode", int'(sclk_out), int'(fe));
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        cycle();
        chk("R1", "reset txd", int'(txd), 1);
        chk("R1", "reset busy", int'(busy), 0);
        chk("R1", "reset done", int'(done), 0);
        chk("R1", "reset irq", int'(irq), 0);
        chk("R1", "reset sclk", int'(sclk_out), 0);

        // R10: ticks while idle
        tick_en = 1'b1; repeat (5) cycle(); tick_en = 1'b0;
        chk("R10", "sclk still idle", int'(sclk_out), 0);

        run_out(8'hA5, 1, 1'b1, 1'b0);
        clr_done = 1'b1; cycle(); clr_done = 1'b0; cycle();
        chk("R8", "clear by write-one", int'(done), 0);

        cfg_fall_edge = 1'b1; repeat (2) cycle();
        chk("R5", "falling mode idle level", int'(sclk_out), 1);
        run_out(8'h3C, 3, 1'b0, 1'b0);
        run_out(8'h81, 2, 1'b1, 1'b1);

        run_in(8'h96, 1'b0);
        run_in(8'h4E, 1'b1);

        cfg_ext_clk = 1'b0; cfg_fall_edge = 1'b0; repeat (3) cycle();
        run_out(8'hFF, 1, 1'b0, 1'b0);
        run_out(8'h00, 2, 1'b0, 1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule